// File: doc/BRIEF.md
# Programmable-Reload Alarm Counter

This block is a one-shot alarm built from a 16-bit up-counter behind a small synchronous register bus. Software picks a count source and a power-of-two prescale, loads a start value and a terminal value, restarts the counter, and enables the interrupt. The counter climbs from the start value to the terminal value. On the next counting tick it falls back to the start value and posts an overflow flag. The interrupt line follows that flag, gated by its enable.

The overflow flag is sticky. Software clears it with a handshake: it must first read the control register while the flag is 1, and then write 0 to the flag bit. An optional threshold suppresses the flag until a chosen number of wraps has accumulated. While that threshold is active, a clear attempt that lands on the same cycle as a wrap that does not complete the count leaves the flag set. Software therefore retries the clear, normally after stopping the count.

Top module: `alarm_timer`

## Requirements
- R1: After reset, the control word reads 0, the counter reads 0, the start value reads 0, the threshold reads 0, the terminal value reads 0x0000FFFF, and irq is 0.
- R2: On a counting tick where the counter equals the terminal value (word 2), the counter reloads with the start value (word 3). On any other counting tick it increments by one.
- R3: With a threshold of 0, the overflow flag (control bit 7) is set on the tick that reloads the counter. Starting from the start value S with terminal value T and prescale exponent P, this happens after (T-S+1)*2^P source pulses.
- R4: A write of any data to the counter word (word 1) loads the start value into the counter. The written data is discarded.
- R5: The source select field (control bits 4:3) chooses the count source. 1 counts every clock cycle. 2 counts pulses of tick_en. 0 and 3 stop the count, so the counter holds its value.
- R6: The prescale field (control bits 2:0) holds P. One counting tick occurs per 2^P source pulses. A stopped source restarts the prescaler, so the first tick after starting comes on the 2^P-th pulse.
- R7: irq is 1 exactly when the overflow flag and the interrupt enable (control bit 6) are both 1.
- R8: A write of 0 to control bit 7 clears the flag only if control word 0 was read (rd_en) while the flag was 1 since the flag was last cleared. A write of 1 to the flag, or a write of 0 without that prior read, leaves it unchanged.
- R9: With a nonzero threshold N (word 4, bits 4:0), the flag is set only on every N-th wrap, counted from the last threshold write.
- R10: With a nonzero threshold, a clear write that coincides with a wrap that is not the N-th leaves the flag set.
- R11: Bits 31:16 of the counter, terminal and start words always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-rate count pulse, one clock wide per pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 3 | Word address: 0 control, 1 counter, 2 terminal, 3 start, 4 threshold |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a clear write that falls on the same clock edge as a wrap while the wrap count is below the threshold. The stimulus sets terminal and start to 0 and counts every cycle, so that every tick is a wrap. It raises the threshold to 31 and waits for the flag. It then arms the clear with a read and writes 0 while the count is still running, so that the write is certain to coincide with a wrap. After that it stops the source and clears again to show that the block recovers. Random terminal, start and prescale choices, together with random tick_en pulse counts, check the wrap timing against a closed-form tick count.

// File: rtl/alarm_timer.sv
module alarm_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PS_W   = 3,
  parameter int THR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [ADDR_W-1:0] A_CTL = 0, A_CNT = 1, A_TOP = 2, A_BASE = 3, A_THR = 4;
  localparam int B_FLAG = 7, B_IE = 6, B_SEL = 3;

  logic              flag_q, ie_q, armed_q;
  logic [1:0]        sel_q;
  logic [PS_W-1:0]   ps_q;
  logic [CNT_W-1:0]  cnt_q, top_q, base_q;
  logic [THR_W-1:0]  thr_q, wcnt_q;
  logic [DIV_W-1:0]  div_q;

  wire unused_hi = ^wdata[DATA_W-1:CNT_W];

  wire ctl_wr  = wr_en && addr == A_CTL;
  wire cnt_wr  = wr_en && addr == A_CNT;
  wire top_wr  = wr_en && addr == A_TOP;
  wire base_wr = wr_en && addr == A_BASE;
  wire thr_wr  = wr_en && addr == A_THR;
  wire ctl_rd  = rd_en && addr == A_CTL;

  logic src;
  always_comb begin
    case (sel_q)
      2'd1:    src = 1'b1;
      2'd2:    src = tick_en;
      default: src = 1'b0;
    endcase
  end
  wire running = sel_q == 2'd1 || sel_q == 2'd2;

  wire [DIV_W-1:0] ps_mask = ~({DIV_W{1'b1}} << ps_q);
  wire cnt_tick = src && ((div_q & ps_mask) == ps_mask);
  wire wrap     = cnt_tick && cnt_q == top_q && !cnt_wr;
  wire thr_on   = thr_q != '0;
  wire set_ev   = wrap && (!thr_on || wcnt_q == thr_q - 1'b1);
  wire clr_ok   = ctl_wr && !wdata[B_FLAG] && armed_q && !(wrap && thr_on);
  wire flag_d   = set_ev ? 1'b1 : (clr_ok ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!running) begin
      div_q <= '0;
    end else if (src) begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr)   cnt_q <= base_q;
    else if (wrap)     cnt_q <= base_q;
    else if (cnt_tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q  <= '1;
      base_q <= '0;
      thr_q  <= '0;
    end else begin
      if (top_wr)  top_q  <= wdata[CNT_W-1:0];
      if (base_wr) base_q <= wdata[CNT_W-1:0];
      if (thr_wr)  thr_q  <= wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sel_q <= 2'd0;
      ps_q  <= '0;
    end else if (ctl_wr) begin
      ie_q  <= wdata[B_IE];
      sel_q <= wdata[B_SEL+1:B_SEL];
      ps_q  <= wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (thr_wr) begin
      wcnt_q <= '0;
    end else if (wrap && thr_on) begin
      wcnt_q <= set_ev ? '0 : wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (!flag_d)               armed_q <= 1'b0;
      else if (ctl_rd && flag_q) armed_q <= 1'b1;
    end
  end

  assign irq = flag_q & ie_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL: begin
        rdata[B_FLAG]          = flag_q;
        rdata[B_IE]            = ie_q;
        rdata[B_SEL+1:B_SEL]   = sel_q;
        rdata[PS_W-1:0]        = ps_q;
      end
      A_CNT:   rdata[CNT_W-1:0] = cnt_q;
      A_TOP:   rdata[CNT_W-1:0] = top_q;
      A_BASE:  rdata[CNT_W-1:0] = base_q;
      A_THR:   rdata[THR_W-1:0] = thr_q;
      default: rdata = '0;
    endcase
  end

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(base_q));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(base_q));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> $stable(cnt_q));
  a_r3_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap));
  a_r8_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q));
endmodule

// File: tb/sim_alarm_timer.sv
`timescale 1ns/1ps
module sim_alarm_timer;
  logic        clk = 0, rst_n = 0, tick_en = 0, wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int checks = 0, fails = 0;

  alarm_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  function automatic int exp_ticks(int top, int base, int ps);
    return (top - base + 1) << ps;
  endfunction

  function automatic int exp_after_pulses(int start, int pulses, int ps);
    return start + pulses / (1 << ps);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a[2:0]; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a[2:0]; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    addr = a[2:0]; #1 d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic clean_stop();
    logic [31:0] d;
    wr(0, 32'h80);
    rd(0, d);
    wr(0, 32'h00);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0;
    int base, top, ps, k, p, tot;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    peek(0, v); check(v == 0, "R1 ctl", v, 0);
    peek(1, v); check(v == 0, "R1 cnt", v, 0);
    peek(2, v); check(v == 32'hFFFF, "R1 top", v, 32'hFFFF);
    peek(3, v); check(v == 0, "R1 base", v, 0);
    peek(4, v); check(v == 0, "R1 thr", v, 0);
    check(irq == 0, "R1 irq", irq, 0);

    // R3 R2 R7: random wrap timing, reload value, interrupt
    for (int t = 0; t < 10; t++) begin
      base = $urandom % 8; top = base + $urandom % 12; ps = $urandom % 3;
      k = exp_ticks(top, base, ps);
      clean_stop();
      wr(2, top); wr(3, base); wr(1, 32'h5555);
      wr(0, 32'h48 | ps);
      repeat (k - 1) @(negedge clk);
      peek(0, v); check(v[7] == 0, "R3 flag early", v[7], 0);
      check(irq == 0, "R7 irq early", irq, 0);
      @(negedge clk);
      peek(0, v); check(v[7] == 1, "R3 flag at wrap", v[7], 1);
      check(irq == 1, "R7 irq at wrap", irq, 1);
      peek(1, v); check(v == base, "R2 reload", v, base);
    end

    // R4 R11
    clean_stop();
    wr(3, 32'h40); wr(1, 32'hABCD);
    peek(1, v); check(v == 32'h40, "R4 cnt load", v, 32'h40);
    wr(2, 32'hFFFF_FFFF);
    peek(2, v); check(v == 32'h0000FFFF, "R11 top upper", v, 32'h0000FFFF);
    wr(3, 32'hFFFF_0005);
    peek(3, v); check(v == 32'h5, "R11 base upper", v, 5);

    // R6: tick_en source with prescale 4
    wr(1, 0);
    wr(0, 32'h12);
    repeat (10) @(negedge clk);
    peek(1, v); check(v == 5, "R6 no pulses", v, 5);
    repeat (8) pulse();
    peek(1, v); check(v == 7, "R6 eight pulses", v, 7);
    repeat (3) pulse();
    peek(1, v); check(v == 7, "R6 partial period", v, 7);
    tot = 11;
    for (int t = 0; t < 3; t++) begin
      p = $urandom % 40;
      repeat (p) pulse();
      tot += p;
      peek(1, v);
      check(v == exp_after_pulses(5, tot, 2), "R6 random pulses", v, exp_after_pulses(5, tot, 2));
    end

    // R5: source select encodings
    peek(1, c0);
    wr(0, 32'h00);
    repeat (10) @(negedge clk);
    peek(1, v); check(v == c0, "R5 sel0 hold", v, c0);
    wr(0, 32'h18);
    repeat (10) @(negedge clk);
    peek(1, v); check(v == c0, "R5 sel3 hold", v, c0);
    wr(0, 32'h08);
    repeat (5) @(negedge clk);
    peek(1, v); check(v == c0 + 5, "R5 sel1 every clock", v, c0 + 5);

    // R7 R8
    clean_stop();
    wr(2, 3); wr(3, 0); wr(1, 0);
    wr(0, 32'h08);
    repeat (4) @(negedge clk);
    peek(0, v); check(v[7] == 1, "R7 flag set", v[7], 1);
    check(irq == 0, "R7 irq masked", irq, 0);
    wr(0, 32'hC0);
    check(irq == 1, "R7 irq enabled", irq, 1);
    wr(0, 32'h40);
    peek(0, v); check(v[7] == 1, "R8 clear without read", v[7], 1);
    rd(0, v);
    wr(0, 32'h40);
    peek(0, v); check(v[7] == 0, "R8 clear after read", v[7], 0);
    check(irq == 0, "R7 irq after clear", irq, 0);
    wr(0, 32'hC0);
    peek(0, v); check(v[7] == 0, "R8 write one", v[7], 0);

    // R9: threshold 3, wrap every 2 cycles
    wr(4, 3); wr(2, 1); wr(3, 0); wr(1, 0);
    wr(0, 32'h48);
    repeat (5) @(negedge clk);
    peek(0, v); check(v[7] == 0, "R9 before third wrap", v[7], 0);
    @(negedge clk);
    peek(0, v); check(v[7] == 1, "R9 third wrap", v[7], 1);

    // R10: clear collides with a non-final wrap
    clean_stop();
    peek(0, v); check(v[7] == 0, "R8 stopped clear", v[7], 0);
    wr(4, 31); wr(2, 0); wr(3, 0); wr(1, 0);
    wr(0, 32'h48);
    repeat (30) @(negedge clk);
    peek(0, v); check(v[7] == 0, "R9 before 31st wrap", v[7], 0);
    @(negedge clk);
    peek(0, v); check(v[7] == 1, "R9 31st wrap", v[7], 1);
    rd(0, v);
    wr(0, 32'h48);
    peek(0, v); check(v[7] == 1, "R10 clear blocked by wrap", v[7], 1);
    wr(0, 32'hC0);
    wr(0, 32'h40);
    peek(0, v); check(v[7] == 0, "R10 clear after stop", v[7], 0);

    finish_run();
  end
endmodule